// File: doc/BRIEF.md
# Inter-processor interrupt mailbox unit

This block sits beside one processor core and lets any agent on the register bus signal that core. It keeps a 32-bit word of pending request bits and a 32-bit mask. The block raises the core's single level-sensitive interrupt line while at least one pending bit is also unmasked. Software cannot write the pending word directly. Bits are raised through a write-1-to-set port and lowered through a write-1-to-clear port. Other cores raise bits by writing the set port of the target core's unit. A side input, `remote_set`, lets the surrounding fabric raise pending bits in the same cycle as a bus access.

Four 64-bit mailbox words carry startup parameters from one core to another. Each mailbox takes full 64-bit accesses. It also takes 32-bit accesses to either half, and such an access leaves the other half as it was. Read data is registered and is returned in the cycle after the read strobe.

Top module: `ipi_mailbox_unit`

## Requirements
- R1: After reset, the pending word, the mask, all four mailboxes, the interrupt output and the read data are all zero.
- R2: A write to offset 0x00 (the pending word) has no effect on any pending bit. A read of 0x00 returns the pending word in bits 31:0.
- R3: A write to offset 0x08 sets every pending bit whose write-data bit is 1 and leaves every other pending bit unchanged.
- R4: A write to offset 0x0C clears every pending bit whose write-data bit is 1 and leaves every other pending bit unchanged.
- R5: Offset 0x04 holds the mask. A write stores write-data bits 31:0, and a read returns them in bits 31:0.
- R6: `irq` is a registered signal. It equals the OR of (pending AND mask) as it stood one cycle earlier, so it changes one clock after the pending word or the mask changes.
- R7: Reads of the write-only offsets 0x08 and 0x0C return zero, and so do reads of any offset that maps to no register.
- R8: Mailboxes 0 to 3 sit at offsets 0x20, 0x28, 0x30 and 0x38. With `bus_wide`=1, a write stores all 64 data bits and a read returns all 64 bits.
- R9: With `bus_wide`=0, a mailbox access reaches the low half when address bit 2 is 0 and the high half when it is 1. The data travels in bus bits 31:0, and a write leaves the other half unchanged. A 32-bit read returns the selected half in bits 31:0, with bits 63:32 zero.
- R10: A bit of `remote_set` sets its pending bit on the next edge. If that bit is cleared through offset 0x0C in the same cycle, the set wins.
- R11: `bus_rdata` is loaded on the edge that samples `bus_rd`=1 and holds its value otherwise. For the 32-bit registers, bits 63:32 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 64 | Write data; 32-bit accesses use bits 31:0 |
| bus_wide | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| remote_set | input | 32 | Per-bit set requests from the fabric |
| bus_rdata | output | 64 | Registered read data |
| irq | output | 1 | Level interrupt to the core |

## Verification
- A write takes effect on the edge that samples it. Reads are therefore issued on the next falling edge, and the bench compares `bus_rdata` one full cycle later, after the edge that loads it.
- The interrupt output trails the pending word by one more register. The bench checks `irq` one falling edge after a write has completed.
- A directed test samples `irq` right after the write edge to show that the line has not yet moved, then samples it again one cycle later.
- The reset test checks the read values and the interrupt one edge after `rst_n` is asserted.

// File: rtl/ipi_pkg.sv
// Package: shared offsets and constants of the inter-processor interrupt unit.
// Assumes byte addressing, with 32-bit registers on 4-byte boundaries.
package ipi_pkg;
    localparam int unsigned OFF_PENDING   = 'h00;
    localparam int unsigned OFF_MASK      = 'h04;
    localparam int unsigned OFF_SET       = 'h08;
    localparam int unsigned OFF_CLEAR     = 'h0C;
    localparam int unsigned OFF_MBOX_BASE = 'h20;
    localparam int unsigned MBOX_STRIDE   = 8;

    typedef enum logic [1:0] {
        RSEL_ZERO    = 2'd0,
        RSEL_PENDING = 2'd1,
        RSEL_MASK    = 2'd2,
        RSEL_MBOX    = 2'd3
    } rsel_e;
endpackage

// File: rtl/ipi_addr_decode.sv
// Module: turns a byte offset into register hits and a mailbox index.
// Assumes ADDR_W is wide enough to reach the last mailbox, with an 8-byte
// mailbox stride. Bits 1:0 of the offset are ignored.
module ipi_addr_decode #(
    parameter int ADDR_W   = 6,
    parameter int NUM_MBOX = 4,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_pending,
    output logic              hit_mask,
    output logic              hit_set,
    output logic              hit_clear,
    output logic              hit_mbox,
    output logic [IDX_W-1:0]  mbox_idx,
    output logic              upper_half
);
    import ipi_pkg::*;

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] mbox_off;
    logic [ADDR_W-1:0] mbox_slot;

    // Word-aligned compare of the 32-bit register offsets.
    always_comb begin
        word_addr   = {addr[ADDR_W-1:2], 2'b00};
        hit_pending = (word_addr == ADDR_W'(OFF_PENDING));
        hit_mask    = (word_addr == ADDR_W'(OFF_MASK));
        hit_set     = (word_addr == ADDR_W'(OFF_SET));
        hit_clear   = (word_addr == ADDR_W'(OFF_CLEAR));
    end

    // Mailbox window: base plus stride times index.
    always_comb begin
        mbox_off   = addr - ADDR_W'(OFF_MBOX_BASE);
        mbox_slot  = mbox_off >> 3;
        hit_mbox   = (addr >= ADDR_W'(OFF_MBOX_BASE)) && (mbox_slot < ADDR_W'(NUM_MBOX));
        mbox_idx   = mbox_slot[IDX_W-1:0];
        upper_half = addr[2];
    end
endmodule

// File: rtl/ipi_status_bank.sv
// Module: holds the pending word and the mask and drives the registered interrupt.
// Assumes at most one bus write per cycle. remote_set may arrive together with a
// clear, and set wins on any bit hit by both.
module ipi_status_bank #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] remote_set,
    output logic [STAT_W-1:0] pending_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq_q
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] pending_d;

    // Merge set and clear requests, with set applied last so that it wins.
    always_comb begin
        set_vec   = (set_wr ? wdata : '0) | remote_set;
        clr_vec   = clr_wr ? wdata : '0;
        pending_d = (pending_q & ~clr_vec) | set_vec;
    end

    // Pending word register.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= pending_d;
    end

    // Mask register, loaded by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata;
    end

    // Interrupt flop, one cycle behind the pending word and the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pending_q & mask_q);
    end
endmodule

// File: rtl/ipi_mailbox_bank.sv
// Module: NUM_MBOX mailbox words, each written whole or one half at a time.
// Assumes MBOX_W is even. Half-width write data arrives in the low half of wdata.
module ipi_mailbox_bank #(
    parameter int NUM_MBOX = 4,
    parameter int MBOX_W   = 64,
    parameter int IDX_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wide,
    input  logic                       upper,
    input  logic [MBOX_W-1:0]          wdata,
    output logic [NUM_MBOX*MBOX_W-1:0] mbox_flat
);
    localparam int HALF_W = MBOX_W / 2;

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_mbox
        logic              sel;
        logic              lo_we;
        logic              hi_we;
        logic [HALF_W-1:0] lo_q;
        logic [HALF_W-1:0] hi_q;

        // Work out which halves of this entry the access writes.
        always_comb begin
            sel   = wr && (idx == IDX_W'(g));
            lo_we = sel && (wide || !upper);
            hi_we = sel && (wide || upper);
        end

        // Low half storage.
        always_ff @(posedge clk) begin
            if (!rst_n)     lo_q <= '0;
            else if (lo_we) lo_q <= wdata[HALF_W-1:0];
        end

        // High half storage, fed from the upper lane only on wide writes.
        always_ff @(posedge clk) begin
            if (!rst_n)     hi_q <= '0;
            else if (hi_we) hi_q <= wide ? wdata[MBOX_W-1:HALF_W] : wdata[HALF_W-1:0];
        end

        assign mbox_flat[g*MBOX_W +: MBOX_W] = {hi_q, lo_q};
    end
endmodule

// File: rtl/ipi_mailbox_unit.sv
// Module: top of the per-core inter-processor interrupt and mailbox unit.
// Assumes one bus access per cycle, reads and writes never in the same cycle,
// and MBOX_W at least twice STAT_W. Read data is registered.
module ipi_mailbox_unit #(
    parameter int STAT_W   = 32,
    parameter int MBOX_W   = 64,
    parameter int NUM_MBOX = 4,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [MBOX_W-1:0] bus_wdata,
    input  logic              bus_wide,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [STAT_W-1:0] remote_set,
    output logic [MBOX_W-1:0] bus_rdata,
    output logic              irq
);
    import ipi_pkg::*;

    localparam int IDX_W  = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;
    localparam int HALF_W = MBOX_W / 2;

    logic                       hit_pending, hit_mask, hit_set, hit_clear, hit_mbox;
    logic [IDX_W-1:0]           mbox_idx;
    logic                       upper_half;
    logic [STAT_W-1:0]          pending_q;
    logic [STAT_W-1:0]          mask_q;
    logic [NUM_MBOX*MBOX_W-1:0] mbox_flat;
    logic [MBOX_W-1:0]          mbox_word;
    rsel_e                      rsel;
    logic [MBOX_W-1:0]          rdata_d;

    ipi_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_MBOX(NUM_MBOX),
        .IDX_W   (IDX_W)
    ) u_decode (
        .addr       (bus_addr),
        .hit_pending(hit_pending),
        .hit_mask   (hit_mask),
        .hit_set    (hit_set),
        .hit_clear  (hit_clear),
        .hit_mbox   (hit_mbox),
        .mbox_idx   (mbox_idx),
        .upper_half (upper_half)
    );

    ipi_status_bank #(
        .STAT_W(STAT_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wr    (bus_wr && hit_set),
        .clr_wr    (bus_wr && hit_clear),
        .mask_wr   (bus_wr && hit_mask),
        .wdata     (bus_wdata[STAT_W-1:0]),
        .remote_set(remote_set),
        .pending_q (pending_q),
        .mask_q    (mask_q),
        .irq_q     (irq)
    );

    ipi_mailbox_bank #(
        .NUM_MBOX(NUM_MBOX),
        .MBOX_W  (MBOX_W),
        .IDX_W   (IDX_W)
    ) u_mbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr && hit_mbox),
        .idx      (mbox_idx),
        .wide     (bus_wide),
        .upper    (upper_half),
        .wdata    (bus_wdata),
        .mbox_flat(mbox_flat)
    );

    // Choose the read source. The write-only and unmapped offsets fall to zero.
    always_comb begin
        if (hit_pending)   rsel = RSEL_PENDING;
        else if (hit_mask) rsel = RSEL_MASK;
        else if (hit_mbox) rsel = RSEL_MBOX;
        else               rsel = RSEL_ZERO;
    end

    // Form the read word, narrowing mailbox reads on 32-bit accesses.
    always_comb begin
        mbox_word = mbox_flat[mbox_idx*MBOX_W +: MBOX_W];
        unique case (rsel)
            RSEL_PENDING: rdata_d = {{(MBOX_W-STAT_W){1'b0}}, pending_q};
            RSEL_MASK:    rdata_d = {{(MBOX_W-STAT_W){1'b0}}, mask_q};
            RSEL_MBOX: begin
                if (bus_wide)        rdata_d = mbox_word;
                else if (upper_half) rdata_d = {{HALF_W{1'b0}}, mbox_word[MBOX_W-1:HALF_W]};
                else                 rdata_d = {{HALF_W{1'b0}}, mbox_word[HALF_W-1:0]};
            end
            default:      rdata_d = '0;
        endcase
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rdata_d;
    end
endmodule

// File: rtl/ipi_mailbox_unit_chk.sv
// Module: checker for ipi_mailbox_unit, attached to it by the bind below.
// Assumes the byte offsets of ipi_pkg. Observes the pending word and the mask
// through the bind.
module ipi_mailbox_unit_chk #(
    parameter int STAT_W = 32,
    parameter int MBOX_W = 64,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [MBOX_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [STAT_W-1:0] remote_set,
    input logic [MBOX_W-1:0] bus_rdata,
    input logic              irq,
    input logic [STAT_W-1:0] pending,
    input logic [STAT_W-1:0] mask
);
    import ipi_pkg::*;

    logic wr_pending, wr_set, wr_clear, wr_mask, rd_wo;

    // Offset matches seen from the checker's side.
    always_comb begin
        wr_pending = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_PENDING >> 2));
        wr_set     = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_SET >> 2));
        wr_clear   = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_CLEAR >> 2));
        wr_mask    = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_MASK >> 2));
        rd_wo      = bus_rd && ((bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_SET >> 2)) ||
                                (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_CLEAR >> 2)));
    end

    // R2
    pending_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pending && remote_set == '0) |=> pending == $past(pending));

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pending & $past(bus_wdata[STAT_W-1:0])) == $past(bus_wdata[STAT_W-1:0])));

    // R4
    clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && remote_set == '0) |=> ((pending & $past(bus_wdata[STAT_W-1:0])) == '0));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> mask == $past(bus_wdata[STAT_W-1:0]));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pending & mask)) |=> irq);

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pending & mask)) |=> !irq);

    // R7
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wo |=> bus_rdata == '0);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_set != '0) |=> ((pending & $past(remote_set)) == $past(remote_set)));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind ipi_mailbox_unit ipi_mailbox_unit_chk #(
    .STAT_W(STAT_W),
    .MBOX_W(MBOX_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .remote_set(remote_set),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pending   (pending_q),
    .mask      (mask_q)
);

// File: tb/ipi_mailbox_unit_tb.sv
`timescale 1ns/1ps
// Bench: walks a table of bus operations with expected results, then runs
// directed tests of the interrupt delay, set-over-clear priority and reset.
module ipi_mailbox_unit_tb;
    localparam int OP_WR  = 0;
    localparam int OP_RD  = 1;
    localparam int OP_IRQ = 2;
    localparam int NVEC   = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_wide = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] remote_set = '0;
    logic [63:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ipi_mailbox_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wide  (bus_wide),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .remote_set(remote_set),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Entry layout: {req[3:0], op[1:0], wide, addr[5:0], data[63:0]}
    localparam logic [76:0] VEC [NVEC] = '{
        {4'd1,  2'd1, 1'b0, 6'h00, 64'h0},                    // R1 pending zero
        {4'd1,  2'd1, 1'b0, 6'h04, 64'h0},                    // R1 mask zero
        {4'd1,  2'd1, 1'b1, 6'h20, 64'h0},                    // R1 mailbox zero
        {4'd5,  2'd0, 1'b0, 6'h04, 64'hFFFF_0000_0000_00F0},  // R5 write mask
        {4'd11, 2'd1, 1'b1, 6'h04, 64'h0000_0000_0000_00F0},  // R5 R11 upper zero
        {4'd3,  2'd0, 1'b0, 6'h08, 64'h0000_0000_0000_0101},  // R3 set
        {4'd3,  2'd1, 1'b0, 6'h00, 64'h0000_0000_0000_0101},  // R3
        {4'd6,  2'd2, 1'b0, 6'h00, 64'h0},                    // R6 masked off
        {4'd3,  2'd0, 1'b0, 6'h08, 64'h0000_0000_0000_0010},  // R3 set bit 4
        {4'd6,  2'd2, 1'b0, 6'h00, 64'h1},                    // R6 irq high
        {4'd3,  2'd1, 1'b0, 6'h00, 64'h0000_0000_0000_0111},  // R3 zeros keep
        {4'd2,  2'd0, 1'b0, 6'h00, 64'h0000_0000_FFFF_FFFF},  // R2 direct write
        {4'd2,  2'd1, 1'b0, 6'h00, 64'h0000_0000_0000_0111},  // R2 unchanged
        {4'd4,  2'd0, 1'b0, 6'h0C, 64'h0000_0000_0000_0010},  // R4 clear
        {4'd6,  2'd2, 1'b0, 6'h00, 64'h0},                    // R6 irq low
        {4'd4,  2'd1, 1'b0, 6'h00, 64'h0000_0000_0000_0101},  // R4
        {4'd7,  2'd1, 1'b0, 6'h08, 64'h0},                    // R7 set reads 0
        {4'd7,  2'd1, 1'b0, 6'h0C, 64'h0},                    // R7 clear reads 0
        {4'd7,  2'd1, 1'b1, 6'h14, 64'h0},                    // R7 unmapped
        {4'd8,  2'd0, 1'b1, 6'h28, 64'h1122_3344_5566_7788},  // R8 wide write
        {4'd8,  2'd1, 1'b1, 6'h28, 64'h1122_3344_5566_7788},  // R8
        {4'd9,  2'd0, 1'b0, 6'h2C, 64'h0000_0000_AABB_CCDD},  // R9 high half
        {4'd9,  2'd1, 1'b1, 6'h28, 64'hAABB_CCDD_5566_7788},  // R9
        {4'd9,  2'd1, 1'b0, 6'h2C, 64'h0000_0000_AABB_CCDD},  // R9
        {4'd9,  2'd1, 1'b0, 6'h28, 64'h0000_0000_5566_7788},  // R9
        {4'd9,  2'd0, 1'b0, 6'h38, 64'h0000_0000_CAFE_F00D},  // R9 low half
        {4'd9,  2'd1, 1'b1, 6'h38, 64'h0000_0000_CAFE_F00D},  // R9
        {4'd8,  2'd1, 1'b1, 6'h20, 64'h0},                    // R8 others intact
        {4'd8,  2'd1, 1'b1, 6'h30, 64'h0}                     // R8
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Each task starts and ends on a falling edge.
    task automatic bus_write(input logic [5:0] a, input logic [63:0] d, input logic w);
        bus_addr = a; bus_wdata = d; bus_wide = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic w, output logic [63:0] d);
        bus_addr = a; bus_wide = w; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {63'd0, irq}, 64'd0);
        check("R1 rdata after reset", bus_rdata, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", VEC[i][76:73], i);
            case (int'(VEC[i][72:71]))
                OP_WR:  bus_write(VEC[i][69:64], VEC[i][63:0], VEC[i][70]);
                OP_RD: begin
                    bus_read(VEC[i][69:64], VEC[i][70], rd);
                    check(tag, rd, VEC[i][63:0]);
                end
                default: begin
                    @(negedge clk);
                    check(tag, {63'd0, irq}, VEC[i][63:0]);
                end
            endcase
        end

        // R11: the read data holds while no read strobe is given.
        bus_addr = 6'h00;
        repeat (2) @(negedge clk);
        check("R11 rdata holds", bus_rdata, 64'd0);

        // R10: remote set and bus clear of bit 2 in one cycle, so the set wins.
        remote_set = 32'h4;
        bus_write(6'h0C, 64'h4, 1'b0);
        remote_set = '0;
        bus_read(6'h00, 1'b0, rd);
        check("R10 set beats clear", rd, 64'h105);

        // R6: the interrupt lags the pending word by one cycle (bit 5 is unmasked).
        bus_write(6'h08, 64'h20, 1'b0);
        check("R6 irq not yet", {63'd0, irq}, 64'd0);
        @(negedge clk);
        check("R6 irq one cycle later", {63'd0, irq}, 64'd1);

        // R6: a mask change also reaches irq after one cycle.
        bus_write(6'h04, 64'h0, 1'b0);
        check("R6 irq before mask takes", {63'd0, irq}, 64'd1);
        @(negedge clk);
        check("R6 irq after mask off", {63'd0, irq}, 64'd0);

        // R1: reset in the middle of a run clears everything.
        bus_write(6'h04, 64'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq in reset", {63'd0, irq}, 64'd0);
        rst_n = 1'b1;
        bus_read(6'h00, 1'b0, rd);
        check("R1 pending cleared", rd, 64'd0);
        bus_read(6'h04, 1'b0, rd);
        check("R1 mask cleared", rd, 64'd0);
        bus_read(6'h28, 1'b1, rd);
        check("R1 mailbox cleared", rd, 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule